// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Controller

This block is the interrupt-fielding side of a backplane with a parameterised number of device slots. Slot 0 is nearest the front of the bus. A device posts a request by pulsing its raise line and states the request's priority level (0 to 3) on its level input. The controller keeps one pending bit for each slot. It compares every pending request with the processor's current priority and raises a single interrupt line when at least one request is eligible.

The processor answers with an acknowledge pulse. The controller then freezes the winning slot, which is the highest eligible level with ties going to the slot nearest the front. The acknowledge runs for a fixed number of cycles. At the end the controller returns the winner's word-aligned vector and its level, with a one-cycle valid strobe. On the next clock it clears that slot's pending bit. Only the frozen slot is answered, so each acknowledge names exactly one source.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A high `raise[i]` at a clock edge sets slot i's pending request. The request stays pending until that slot is served, whatever its eligibility.
- R2: A pending request is eligible only when its level (`dev_level[2*i+:2]`) is strictly greater than `cur_prio`. `irq_req` is registered and equals "any eligible request" one clock after the inputs settle.
- R3: Among eligible requests, the one with the numerically highest level is served first.
- R4: Among eligible requests of equal level, the lowest slot index (nearest the front) is served first.
- R5: The winner is captured at the edge where `iak` is accepted. Requests raised later, even at a higher level, do not change the vector or level that this acknowledge returns.
- R6: `vec_valid` rises on the ACK_CYC-th clock edge after the accepting edge and lasts exactly one cycle. It comes with `vec_out`, which is the winner's `slot_vec` field with bit 0 forced to 0, and with `vec_level`, which is the winner's level.
- R7: The served slot's pending bit clears on the edge after `vec_valid` rises. All other pending requests are kept.
- R8: `iak` is ignored when no request is eligible, and also while an acknowledge is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise | input | NUM_SLOTS | Request pulse per slot |
| dev_level | input | 2*NUM_SLOTS | Request level per slot, two bits each |
| slot_vec | input | VEC_W*NUM_SLOTS | Fixed vector per slot |
| cur_prio | input | 2 | Current processor priority |
| iak | input | 1 | Acknowledge start from the processor |
| irq_req | output | 1 | An eligible request is pending |
| vec_valid | output | 1 | One-cycle strobe at acknowledge end |
| vec_out | output | VEC_W | Returned vector, bit 0 zero |
| vec_level | output | 2 | Level of the served request |

## Verification
The bench builds the block with eight slots, 9-bit vectors and a two-cycle acknowledge. Eight slots are enough to place same-level requests in the middle and at the back of the bus, and to have requests at all four levels pending at once. A two-cycle acknowledge leaves a gap inside the cycle in which a late higher-level request can be injected. Each slot's vector has bit 0 set, so the alignment forcing shows up in every returned value.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} ack_st_t;
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] raise,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NUM_SLOTS-1:0] pend
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = clr_en && (clr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)           pend[g] <= 1'b0;
      else if (raise[g]) pend[g] <= 1'b1;
      else if (hit)      pend[g] <= 1'b0;
    end
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (hit && !raise[g]) |=> !pend[g]);
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
      (pend[g] && !hit) |=> pend[g]);
  end
endmodule

// File: rtl/vic_select.sv
module vic_select
  import vic_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0]       pend,
  input  logic [LVL_W*NUM_SLOTS-1:0] dev_level,
  input  lvl_t                       cur_prio,
  output logic                       any,
  output logic [IDX_W-1:0]           win_idx,
  output lvl_t                       win_lvl
);
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (pend[i] && (dev_level[LVL_W*i +: LVL_W] > cur_prio) &&
          (!any || dev_level[LVL_W*i +: LVL_W] > win_lvl)) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = dev_level[LVL_W*i +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/vic_ack.sv
module vic_ack
  import vic_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VEC_W     = 9,
  parameter int ACK_CYC   = 2,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W = $clog2(ACK_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iak,
  input  logic             any,
  input  logic [IDX_W-1:0] win_idx,
  input  lvl_t             win_lvl,
  input  logic [VEC_W-1:0] win_vec,
  input  lvl_t             cur_prio,
  output logic             irq_req,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out,
  output lvl_t             vec_level,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx
);
  ack_st_t          state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] cap_idx;
  lvl_t             cap_lvl;
  logic [VEC_W-1:0] cap_vec;

  assign clr_en  = (state == ST_DONE);
  assign clr_idx = cap_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cap_idx   <= '0;
      cap_lvl   <= '0;
      cap_vec   <= '0;
      irq_req   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      vec_level <= '0;
    end else begin
      irq_req   <= any;
      vec_valid <= 1'b0;
      case (state)
        ST_IDLE: if (iak && any) begin
          state   <= ST_BUSY;
          cnt     <= '0;
          cap_idx <= win_idx;
          cap_lvl <= win_lvl;
          cap_vec <= {win_vec[VEC_W-1:1], 1'b0};
        end
        ST_BUSY: if (cnt == CNT_W'(ACK_CYC - 1)) begin
          state     <= ST_DONE;
          vec_out   <= cap_vec;
          vec_level <= cap_lvl;
          vec_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);
  assert_align_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> !vec_out[0]);
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && iak && any) |=> (cap_lvl > $past(cur_prio)));
  assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY && iak) |=> ($stable(cap_idx) && $stable(cap_vec)));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VEC_W     = 9,
  parameter int ACK_CYC   = 2,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SLOTS-1:0]       raise,
  input  logic [2*NUM_SLOTS-1:0]     dev_level,
  input  logic [VEC_W*NUM_SLOTS-1:0] slot_vec,
  input  logic [1:0]                 cur_prio,
  input  logic                       iak,
  output logic                       irq_req,
  output logic                       vec_valid,
  output logic [VEC_W-1:0]           vec_out,
  output logic [1:0]                 vec_level
);
  logic [NUM_SLOTS-1:0] pend;
  logic                 any, clr_en;
  logic [IDX_W-1:0]     win_idx, clr_idx;
  lvl_t                 win_lvl;

  vic_pend #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
    .clk(clk), .rst(rst), .raise(raise), .clr_en(clr_en),
    .clr_idx(clr_idx), .pend(pend));

  vic_select #(.NUM_SLOTS(NUM_SLOTS)) u_sel (
    .pend(pend), .dev_level(dev_level), .cur_prio(cur_prio),
    .any(any), .win_idx(win_idx), .win_lvl(win_lvl));

  vic_ack #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W), .ACK_CYC(ACK_CYC)) u_ack (
    .clk(clk), .rst(rst), .iak(iak), .any(any), .win_idx(win_idx),
    .win_lvl(win_lvl), .win_vec(slot_vec[VEC_W*win_idx +: VEC_W]),
    .cur_prio(cur_prio), .irq_req(irq_req), .vec_valid(vec_valid),
    .vec_out(vec_out), .vec_level(vec_level), .clr_en(clr_en),
    .clr_idx(clr_idx));

  assert_winner_R3: assert property (@(posedge clk) disable iff (rst)
    any |-> (pend[win_idx] && win_lvl > cur_prio));
  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!any && !clr_en) |=> !vec_valid);
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int N = 8, VW = 9, AC = 2;
  logic clk = 0, rst = 1, iak = 0;
  logic [N-1:0] raise = '0;
  logic [2*N-1:0] dev_level = '0;
  logic [VW*N-1:0] slot_vec;
  logic [1:0] cur_prio = 0;
  logic irq_req, vec_valid;
  logic [VW-1:0] vec_out;
  logic [1:0] vec_level;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_vec
    assign slot_vec[VW*g +: VW] = VW'(9'h101 + g*4);
  end

  vec_irq_ctrl #(.NUM_SLOTS(N), .VEC_W(VW), .ACK_CYC(AC)) uut (
    .clk(clk), .rst(rst), .raise(raise), .dev_level(dev_level),
    .slot_vec(slot_vec), .cur_prio(cur_prio), .iak(iak),
    .irq_req(irq_req), .vec_valid(vec_valid), .vec_out(vec_out),
    .vec_level(vec_level));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic post(input int slot, input int lvl);
    @(negedge clk);
    dev_level[2*slot +: 2] = 2'(lvl);
    raise[slot] = 1'b1;
    @(negedge clk);
    raise = '0;
  endtask

  // Run one acknowledge; optionally raise a slot midway (R5).
  task automatic serve(input string req, input int slot, input int lvl,
                       input int late_slot, input int late_lvl);
    int k = 0;
    @(negedge clk);
    iak = 1;
    while (k < 20) begin
      @(negedge clk);
      iak = 0;
      k++;
      if (k == 1 && late_slot >= 0) begin
        dev_level[2*late_slot +: 2] = 2'(late_lvl);
        raise[late_slot] = 1;
      end else raise = '0;
      if (vec_valid) break;
    end
    raise = '0;
    check({req, " latency"}, k, AC + 1);
    check({req, " vector"}, int'(vec_out), 9'h100 + slot*4);
    check({req, " level"}, int'(vec_level), lvl);
    @(negedge clk);
    check("R6 pulse", int'(vec_valid), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset irq", int'(irq_req), 0);
    check("R6 reset valid", int'(vec_valid), 0);
  endtask

  task automatic t_threshold();
    int seen = 0;
    cur_prio = 1;
    post(3, 1);
    @(negedge clk);
    check("R2 level equal prio not eligible", int'(irq_req), 0);
    iak = 1;
    repeat (6) begin
      @(negedge clk);
      iak = 0;
      seen += int'(vec_valid);
    end
    check("R8 iak ignored when none eligible", seen, 0);
    cur_prio = 0;
    @(negedge clk);
    check("R2 eligible after prio drop", int'(irq_req), 1);
  endtask

  task automatic t_levels();
    post(2, 2);
    post(5, 3);
    @(negedge clk);
    serve("R3 highest level", 5, 3, -1, 0);
    serve("R7 others kept", 2, 2, -1, 0);
  endtask

  task automatic t_ties();
    post(6, 2);
    post(4, 2);
    @(negedge clk);
    serve("R4 front slot wins tie", 4, 2, -1, 0);
  endtask

  task automatic t_freeze();
    serve("R5 winner frozen", 6, 2, 0, 3);
    serve("R5 late request served next", 0, 3, -1, 0);
    serve("R1 low request still pending", 3, 1, -1, 0);
    @(negedge clk);
    check("R7 all served", int'(irq_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_levels();
    t_ties();
    t_freeze();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule